// File: doc/BRIEF.md
# Automatic Serial Bit-Rate Detector

This block measures the bit rate of an asynchronous serial host. The host repeatedly sends the byte 0x00 in 8N1 format, with one start bit, eight data bits and one stop bit. On the line, each such frame is a single low stretch nine bit-times long, followed by a high stop bit. The receive line first passes through a flop synchroniser. A counter then times each low stretch, from the synchronised falling edge to the next rising edge, in clock cycles.

A tracker compares each measurement with the first one of the current run. Once four measurements in a row agree within about 3%, the block takes their sum, divides it by 36 (four frames of nine bit-times each) and loads the result into a divisor register for a companion serial receiver. At the same time it pulses a lock strobe, which can trigger the one-byte 0x00 reply that signals the end of calibration. The block also raises a sticky locked level. It then ignores the line until a synchronous re-arm request.

A low stretch that is too long is reported as a timeout and discarded. Glitches that are too short are dropped without disturbing the run. This lets the detector follow common host rates such as 4800 and 9600 baud, down to the limit set by the maximum-count parameter.

Top module: `uart_baud_detect`

## Requirements
- R1: While rst_ni is low and after its release, divisor_o is 0 and lock_o, locked_o and timeout_o are 0.
- R2: A measurement equals the number of rising clock edges at which rxd_i is sampled low, between a high-to-low transition and the next low-to-high transition.
- R3: A measurement belongs to the current run when its absolute difference from the run's first measurement is at most that first measurement shifted right by 5, i.e. floor(ref/32).
- R4: Lock requires 4 consecutive in-tolerance measurements. A measurement out of tolerance starts a new run, with itself as the new reference.
- R5: On lock, divisor_o becomes floor((S + 18) / 36), where S is the sum of the run's 4 measurements.
- R6: lock_o is a pulse one cycle long. divisor_o changes only in the cycle where lock_o is high. locked_o stays high after lock.
- R7: A low stretch longer than MAX_LOW cycles gives one timeout_o pulse, is discarded, and clears the current run. A stretch of exactly MAX_LOW cycles is measured normally.
- R8: A low stretch shorter than MIN_LOW (default 9) cycles is ignored and leaves the current run unchanged.
- R9: While locked_o is high, new measurements cause no lock pulse and leave divisor_o unchanged.
- R10: A one-cycle rearm_i clears locked_o and the run, and abandons any low stretch in progress. divisor_o keeps its value.
- R11: lock_o is high in the cycle that follows the third rising clock edge after the first edge at which rxd_i is sampled high at the end of the final frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rearm_i | input | 1 | Synchronous request to restart detection |
| rxd_i | input | 1 | Asynchronous serial receive line, idle high |
| divisor_o | output | DIV_W | Clocks per bit, loaded on lock |
| lock_o | output | 1 | One-cycle pulse when lock is reached |
| locked_o | output | 1 | High from lock until re-arm |
| timeout_o | output | 1 | One-cycle pulse when a low stretch exceeds MAX_LOW |

## Verification
The bound checker watches several properties on every cycle:
- lock_o lasts exactly one cycle, and divisor_o moves only with it.
- No second lock occurs while locked, and re-arm clears the lock.
- A lock never reports a zero divisor, and a timeout never coincides with a lock.

Some behaviour can only be shown by the bench's frame sequences: the arithmetic of the averaged divisor, the exact tolerance edge at floor(ref/32), run restarts on mismatch, timeouts and glitches, the MAX_LOW boundary, abandonment of a stretch cut by re-arm, and the lock latency.

// File: rtl/bd_pkg.sv
package bd_pkg;
  // an all-zero 8N1 frame holds the line low for start + 8 data bits
  localparam int unsigned ZERO_FRAME_BITS = 9;
  localparam int unsigned SYNC_DEPTH      = 2;
endpackage

// File: rtl/bd_sync.sv
module bd_sync #(
  parameter int unsigned STAGES = bd_pkg::SYNC_DEPTH
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic fall_o,
  output logic rise_o
);
  logic [STAGES-1:0] sr_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '1;
      prev_q <= 1'b1;
    end else begin
      sr_q   <= {sr_q[STAGES-2:0], d_i};
      prev_q <= sr_q[STAGES-1];
    end
  end

  assign fall_o = prev_q & ~sr_q[STAGES-1];
  assign rise_o = ~prev_q & sr_q[STAGES-1];
endmodule

// File: rtl/bd_low_timer.sv
module bd_low_timer #(
  parameter int unsigned CNT_W   = 22,
  parameter int unsigned MAX_LOW = 1_900_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             fall_i,
  input  logic             rise_i,
  output logic             meas_vld_o,
  output logic [CNT_W-1:0] meas_o,
  output logic             timeout_o
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_LOW);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      cnt_q      <= '0;
      meas_vld_o <= 1'b0;
      meas_o     <= '0;
      timeout_o  <= 1'b0;
    end else begin
      meas_vld_o <= 1'b0;
      timeout_o  <= 1'b0;
      if (clear_i) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (rise_i) begin
          busy_q     <= 1'b0;
          meas_vld_o <= 1'b1;
          meas_o     <= cnt_q;
        end else if (cnt_q == LIMIT) begin
          busy_q    <= 1'b0;
          timeout_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (fall_i) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/bd_lock_track.sv
module bd_lock_track #(
  parameter int unsigned CNT_W     = 22,
  parameter int unsigned DIV_W     = 18,
  parameter int unsigned LOCK_RUNS = 4,
  parameter int unsigned TOL_SHIFT = 5,
  parameter int unsigned MIN_LOW   = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             discard_i,
  input  logic             meas_vld_i,
  input  logic [CNT_W-1:0] meas_i,
  output logic             lock_o,
  output logic             locked_o,
  output logic [DIV_W-1:0] divisor_o
);
  localparam int unsigned RUN_W = $clog2(LOCK_RUNS + 1);
  localparam int unsigned SUM_W = CNT_W + $clog2(LOCK_RUNS) + 1;
  localparam int unsigned DEN   = bd_pkg::ZERO_FRAME_BITS * LOCK_RUNS;
  localparam logic [SUM_W-1:0] DEN_V  = SUM_W'(DEN);
  localparam logic [SUM_W-1:0] HALF_V = SUM_W'(DEN / 2);

  logic [RUN_W-1:0] run_q;
  logic [CNT_W-1:0] ref_q;
  logic [SUM_W-1:0] sum_q, sum_nxt;
  logic [CNT_W-1:0] diff;
  logic             in_tol, accept;

  assign diff    = (meas_i >= ref_q) ? meas_i - ref_q : ref_q - meas_i;
  assign in_tol  = diff <= (ref_q >> TOL_SHIFT);
  assign accept  = meas_vld_i & ~locked_o & (meas_i >= CNT_W'(MIN_LOW));
  assign sum_nxt = sum_q + SUM_W'(meas_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= '0;
      ref_q     <= '0;
      sum_q     <= '0;
      lock_o    <= 1'b0;
      locked_o  <= 1'b0;
      divisor_o <= '0;
    end else begin
      lock_o <= 1'b0;
      if (clear_i) begin
        run_q    <= '0;
        locked_o <= 1'b0;
      end else if (discard_i) begin
        run_q <= '0;
      end else if (accept) begin
        if (run_q == '0 || !in_tol) begin
          ref_q <= meas_i;
          sum_q <= SUM_W'(meas_i);
          run_q <= RUN_W'(1);
        end else if (run_q == RUN_W'(LOCK_RUNS - 1)) begin
          run_q     <= '0;
          lock_o    <= 1'b1;
          locked_o  <= 1'b1;
          divisor_o <= DIV_W'((sum_nxt + HALF_V) / DEN_V);
        end else begin
          run_q <= run_q + 1'b1;
          sum_q <= sum_nxt;
        end
      end
    end
  end
endmodule

// File: rtl/uart_baud_detect.sv
module uart_baud_detect #(
  parameter int unsigned CNT_W     = 22,
  parameter int unsigned DIV_W     = 18,
  parameter int unsigned MAX_LOW   = 1_900_000,
  parameter int unsigned MIN_LOW   = 9,
  parameter int unsigned LOCK_RUNS = 4,
  parameter int unsigned TOL_SHIFT = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rearm_i,
  input  logic             rxd_i,
  output logic [DIV_W-1:0] divisor_o,
  output logic             lock_o,
  output logic             locked_o,
  output logic             timeout_o
);
  logic             fall, rise, meas_vld;
  logic [CNT_W-1:0] meas;

  bd_sync #(.STAGES(bd_pkg::SYNC_DEPTH)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (rxd_i),
    .fall_o (fall),
    .rise_o (rise)
  );

  bd_low_timer #(.CNT_W(CNT_W), .MAX_LOW(MAX_LOW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (rearm_i),
    .fall_i     (fall),
    .rise_i     (rise),
    .meas_vld_o (meas_vld),
    .meas_o     (meas),
    .timeout_o  (timeout_o)
  );

  bd_lock_track #(
    .CNT_W(CNT_W), .DIV_W(DIV_W), .LOCK_RUNS(LOCK_RUNS),
    .TOL_SHIFT(TOL_SHIFT), .MIN_LOW(MIN_LOW)
  ) u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (rearm_i),
    .discard_i  (timeout_o),
    .meas_vld_i (meas_vld),
    .meas_i     (meas),
    .lock_o     (lock_o),
    .locked_o   (locked_o),
    .divisor_o  (divisor_o)
  );
endmodule

// File: rtl/uart_baud_detect_chk.sv
module uart_baud_detect_chk #(
  parameter int unsigned DIV_W = 18
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rearm_i,
  input logic [DIV_W-1:0] divisor_o,
  input logic             lock_o,
  input logic             locked_o,
  input logic             timeout_o
);
  assert_lock_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |=> !lock_o);

  assert_div_moves_on_lock_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (divisor_o != $past(divisor_o)) |-> lock_o);

  assert_no_relock_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |-> !$past(locked_o));

  assert_rearm_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rearm_i |=> (!locked_o && !lock_o));

  assert_div_nonzero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |-> (divisor_o != '0));

  assert_timeout_not_lock_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> !lock_o);
endmodule

bind uart_baud_detect uart_baud_detect_chk #(.DIV_W(DIV_W)) u_chk (.*);

// File: tb/uart_baud_detect_tb.sv
module uart_baud_detect_tb;
  localparam int DIV_W = 12;
  localparam int GAP   = 12;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             rearm_i = 1'b0;
  logic             rxd_i = 1'b1;
  logic [DIV_W-1:0] divisor_o;
  logic             lock_o, locked_o, timeout_o;

  int n_run = 0, n_fail = 0;
  int cyc = 0, rise_cyc = 0, lock_at = 0;
  int lock_cnt = 0, to_cnt = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  uart_baud_detect #(
    .CNT_W(16), .DIV_W(DIV_W), .MAX_LOW(1000), .MIN_LOW(9),
    .LOCK_RUNS(4), .TOL_SHIFT(5)
  ) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .rearm_i(rearm_i), .rxd_i(rxd_i),
    .divisor_o(divisor_o), .lock_o(lock_o), .locked_o(locked_o),
    .timeout_o(timeout_o)
  );

  always @(posedge clk_i) cyc <= cyc + 1;

  always @(negedge clk_i) begin
    if (lock_o) begin lock_cnt = lock_cnt + 1; lock_at = cyc; end
    if (timeout_o) to_cnt = to_cnt + 1;
  end

  // lows per row, then expected divisor
  localparam int VEC [4][5] = '{
    '{180, 180, 180, 180, 20},
    '{450, 452, 448, 451, 50},
    '{ 90,  92,  88,  91, 10},
    '{900, 900, 880, 910, 100}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic frame(input int len);
    @(negedge clk_i) rxd_i = 1'b0;
    repeat (len) @(negedge clk_i);
    rxd_i = 1'b1;
    rise_cyc = cyc;
    repeat (GAP) @(negedge clk_i);
  endtask

  task automatic rearm();
    @(negedge clk_i) rearm_i = 1'b1;
    @(negedge clk_i) rearm_i = 1'b0;
    lock_cnt = 0;
    to_cnt = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(divisor_o == 0 && !lock_o && !locked_o && !timeout_o, "R1 in reset",
          int'(divisor_o) + int'(locked_o), 0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    check(divisor_o == 0 && !lock_o && !locked_o && !timeout_o, "R1 after release",
          int'(divisor_o) + int'(locked_o), 0);

    // table: four matching frames per row -> one lock, averaged divisor
    for (int r = 0; r < 4; r++) begin
      rearm();
      for (int k = 0; k < 4; k++) frame(VEC[r][k]);
      check(lock_cnt == 1, "R4 table lock count", lock_cnt, 1);
      check(int'(divisor_o) == VEC[r][4], "R5 R2 table divisor", int'(divisor_o), VEC[r][4]);
      check(locked_o == 1'b1, "R6 locked level", int'(locked_o), 1);
      if (r == 0) check(lock_at - rise_cyc == 4, "R11 lock latency", lock_at - rise_cyc, 4);
    end

    // R4: mismatch restarts the run with the new value as reference
    rearm();
    frame(180); frame(180); frame(200); frame(200); frame(200);
    check(lock_cnt == 0, "R4 no lock after mismatch", lock_cnt, 0);
    frame(200);
    check(lock_cnt == 1, "R4 lock on new run", lock_cnt, 1);
    check(divisor_o == 22, "R4 new run divisor", int'(divisor_o), 22);

    // R3: +5/-5 on ref 180 is inside tolerance
    rearm();
    frame(180); frame(185); frame(175); frame(180);
    check(lock_cnt == 1, "R3 edge accepted", lock_cnt, 1);
    check(divisor_o == 20, "R3 edge divisor", int'(divisor_o), 20);

    // R3: +6 on ref 180 is outside
    rearm();
    frame(180); frame(186); frame(180); frame(180);
    check(lock_cnt == 0, "R3 beyond edge rejected", lock_cnt, 0);
    frame(180); frame(180);
    check(lock_cnt == 1, "R3 relock after reject", lock_cnt, 1);

    // R8: a short glitch does not disturb the run
    rearm();
    frame(180); frame(180); frame(4); frame(180);
    check(lock_cnt == 0, "R8 glitch not counted", lock_cnt, 0);
    frame(180);
    check(lock_cnt == 1, "R8 run kept across glitch", lock_cnt, 1);

    // R7: over-long low times out and clears run
    rearm();
    frame(180); frame(180); frame(180); frame(1200);
    check(to_cnt == 1, "R7 timeout pulse", to_cnt, 1);
    check(lock_cnt == 0, "R7 no lock on timeout", lock_cnt, 0);
    frame(180);
    check(lock_cnt == 0, "R7 run cleared", lock_cnt, 0);
    frame(180); frame(180); frame(180);
    check(lock_cnt == 1, "R7 lock after timeout", lock_cnt, 1);

    // R7: exactly MAX_LOW is measured
    rearm();
    for (int k = 0; k < 4; k++) frame(1000);
    check(to_cnt == 0, "R7 max low no timeout", to_cnt, 0);
    check(divisor_o == 111, "R7 max low divisor", int'(divisor_o), 111);

    // R9: ignored while locked
    for (int k = 0; k < 4; k++) frame(90);
    check(lock_cnt == 1, "R9 no relock", lock_cnt, 1);
    check(divisor_o == 111, "R9 divisor held", int'(divisor_o), 111);

    // R10: rearm clears lock, keeps divisor, abandons stretch in progress
    rearm();
    check(!locked_o, "R10 locked cleared", int'(locked_o), 0);
    check(divisor_o == 111, "R10 divisor kept", int'(divisor_o), 111);
    @(negedge clk_i) rxd_i = 1'b0;
    repeat (90) @(negedge clk_i);
    rearm_i = 1'b1;
    @(negedge clk_i) rearm_i = 1'b0;
    repeat (90) @(negedge clk_i);
    rxd_i = 1'b1;
    repeat (GAP) @(negedge clk_i);
    frame(180); frame(180); frame(180);
    check(lock_cnt == 0, "R10 partial stretch dropped", lock_cnt, 0);
    frame(180);
    check(lock_cnt == 1, "R10 lock after rearm", lock_cnt, 1);
    check(divisor_o == 20, "R10 new divisor", int'(divisor_o), 20);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule